// File: doc/BRIEF.md
# Security-Aliased Address Attribution and Decode Unit

This block answers one question per request: given a 32-bit bus address, which security attributes does it carry and which target does it reach? The attributes come from the address alone. The region ID is the top nibble. Bit 28 selects secure or non-secure. An exempt flag covers the first megabyte of the two top regions. A non-secure-callable flag is granted to region 1 or region 3 only when the matching bit of a two-bit configuration register is set.

Each resource appears twice in the map, once in a non-secure half and once in a secure half. Decoding first folds the secure mirrors 0x1, 0x3 and 0x5 onto 0x0, 0x2 and 0x4. It then produces a one-hot target select and an offset inside that target. Folding has the lowest priority: a device mapped directly in the 0x5 region wins over the alias of the 0x4 region beneath it.

Lookups are pipelined one stage deep. The configuration register sits behind a small request port that only secure requesters may write.

Top module: `addr_attr_unit`

## Requirements
- R1: `rsp_region` equals request address bits [31:28]. `rsp_nonsec` is 1 exactly when address bit 28 is 0.
- R2: `rsp_nsc` is 1 only in two cases: region 1 with configuration bit 0 set, or region 3 with configuration bit 1 set. It is 0 for every other region.
- R3: `rsp_exempt` is 1 exactly when (address & 0xEFF00000) == 0xE0000000.
- R4: After reset, `rsp_valid`, `cfg_denied` and `cfg_rdata` are 0, and every response output is 0.
- R5: `rsp_valid` is high for exactly the one cycle after a cycle with `req_valid` high. While `req_valid` is low, the response fields hold their values.
- R6: Addresses in regions 0x1, 0x3 and 0x5 decode as the same address with bit 28 cleared. They give the same target and the same offset as the non-secure copy.
- R7: `rsp_target` is one-hot, with these bits:
  - bit 0: SRAM, 32 KB at 0x2000_0000.
  - bits 1..3: 4 KB peripheral slots at 0x4000_0000, 0x4000_1000 and 0x4000_2000.
  - bit 4: 4 KB slow-clock timer slot at 0x4002_F000.
  - bit 5: secure-only control window.
  - bit 6: non-secure control window at 0x4008_0000.
  - bit 7: error slave.

  For bits 0 to 6, `rsp_offset` is the address modulo the target size.
- R8: Addresses 0x5008_0000 to 0x5008_0FFF select bit 5 and not the folded non-secure window (bit 6).
- R9: An address that matches no target selects bit 7. Its `rsp_offset` equals the folded address.
- R10: A write with `cfg_secure`=1 loads `cfg_wdata` into the configuration register, which is visible on `cfg_rdata` the next cycle. A write with `cfg_secure`=0 leaves the register unchanged and raises `cfg_denied` for one cycle.
- R11: A lookup in the same cycle as a configuration write uses the register value from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Lookup request strobe |
| req_addr | input | 32 | Address to attribute and decode |
| rsp_valid | output | 1 | Response valid, one cycle after a request |
| rsp_region | output | 4 | Region ID |
| rsp_nonsec | output | 1 | Non-secure attribute |
| rsp_nsc | output | 1 | Non-secure-callable attribute |
| rsp_exempt | output | 1 | Exempt attribute |
| rsp_target | output | 8 | One-hot target select |
| rsp_offset | output | 32 | Offset within target (folded address for error slave) |
| cfg_valid | input | 1 | Configuration port strobe |
| cfg_write | input | 1 | 1 = write access |
| cfg_secure | input | 1 | Secure attribute of the requester |
| cfg_wdata | input | 2 | Write data for the configuration register |
| cfg_rdata | output | 2 | Current configuration register value |
| cfg_denied | output | 1 | One-cycle pulse after a rejected non-secure write |

## Verification
A lookup and a configuration write can land in the same cycle. The NSC result then depends on which register value the attribute logic sees. The bench provokes this by strobing a region-1 lookup together with a secure write that sets both bits. The response must still show NSC cleared, while `cfg_rdata` already shows the new value. A second lookup afterwards must show NSC set. A rejected non-secure write is also paired with a later lookup, which confirms that the register did not change.

// File: rtl/aau_pkg.sv
package aau_pkg;
  localparam int ADDR_W  = 32;
  localparam int N_PSLOT = 3;
  localparam int N_TGT   = N_PSLOT + 5;

  localparam int IDX_SRAM   = 0;
  localparam int IDX_PSLOT0 = 1;
  localparam int IDX_SLOW   = IDX_PSLOT0 + N_PSLOT;
  localparam int IDX_CTL_S  = IDX_SLOW + 1;
  localparam int IDX_CTL_NS = IDX_CTL_S + 1;
  localparam int IDX_ERR    = IDX_CTL_NS + 1;

  typedef struct packed {
    logic [3:0] region;
    logic       nonsec;
    logic       nsc;
    logic       exempt;
  } attr_t;

  function automatic logic [3:0] region_of(input logic [ADDR_W-1:0] a);
    return a[31:28];
  endfunction

  function automatic logic nsc_of(input logic [ADDR_W-1:0] a, input logic [1:0] cfg);
    return (a[31:28] == 4'd1 && cfg[0]) || (a[31:28] == 4'd3 && cfg[1]);
  endfunction

  function automatic logic exempt_of(input logic [ADDR_W-1:0] a);
    return (a & 32'hEFF0_0000) == 32'hE000_0000;
  endfunction

  // secure mirrors 1/3/5 fold onto 0/2/4
  function automatic logic [ADDR_W-1:0] fold_of(input logic [ADDR_W-1:0] a);
    logic [ADDR_W-1:0] f;
    f = a;
    if (a[31:28] == 4'd1 || a[31:28] == 4'd3 || a[31:28] == 4'd5) f[28] = 1'b0;
    return f;
  endfunction
endpackage

// File: rtl/aau_attr.sv
module aau_attr
  import aau_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        cfg,
  output attr_t             attr
);
  always_comb begin
    attr.region = region_of(addr);
    attr.nonsec = ~addr[28];
    attr.nsc    = nsc_of(addr, cfg);
    attr.exempt = exempt_of(addr);
  end
endmodule

// File: rtl/aau_cfg.sv
module aau_cfg (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       valid,
  input  logic       write,
  input  logic       secure,
  input  logic [1:0] wdata,
  output logic [1:0] cfg,
  output logic       denied,
  output logic       wr_ok,
  output logic       wr_reject
);
  assign wr_ok     = valid & write & secure;
  assign wr_reject = valid & write & ~secure;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg    <= 2'b00;
      denied <= 1'b0;
    end else begin
      if (wr_ok) cfg <= wdata;
      denied <= wr_reject;
    end
  end
endmodule

// File: rtl/aau_decode.sv
module aau_decode
  import aau_pkg::*;
#(
  parameter int                SRAM_BYTES  = 32768,
  parameter int                SLOT_BYTES  = 4096,
  parameter logic [ADDR_W-1:0] SRAM_BASE   = 32'h2000_0000,
  parameter logic [ADDR_W-1:0] PSLOT_BASE  = 32'h4000_0000,
  parameter logic [ADDR_W-1:0] SLOW_BASE   = 32'h4002_F000,
  parameter logic [ADDR_W-1:0] CTL_NS_BASE = 32'h4008_0000,
  parameter logic [ADDR_W-1:0] CTL_S_BASE  = 32'h5008_0000
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [N_TGT-1:0]  tgt,
  output logic [ADDR_W-1:0] offset,
  output logic              direct_hit,
  output logic              folded_any
);
  localparam int SRAM_AW = $clog2(SRAM_BYTES);
  localparam int SLOT_AW = $clog2(SLOT_BYTES);
  localparam logic [ADDR_W-1:0] SRAM_MASK = ADDR_W'(SRAM_BYTES - 1);
  localparam logic [ADDR_W-1:0] SLOT_MASK = ADDR_W'(SLOT_BYTES - 1);

  logic [ADDR_W-1:0]  folded;
  logic               sram_hit, slow_hit, ctl_ns_hit;
  logic [N_PSLOT-1:0] slot_hit;

  assign folded     = fold_of(addr);
  assign folded_any = (folded != addr);
  assign direct_hit = addr[ADDR_W-1:SLOT_AW] == CTL_S_BASE[ADDR_W-1:SLOT_AW];
  assign sram_hit   = folded[ADDR_W-1:SRAM_AW] == SRAM_BASE[ADDR_W-1:SRAM_AW];
  assign slow_hit   = folded[ADDR_W-1:SLOT_AW] == SLOW_BASE[ADDR_W-1:SLOT_AW];
  assign ctl_ns_hit = folded[ADDR_W-1:SLOT_AW] == CTL_NS_BASE[ADDR_W-1:SLOT_AW];

  for (genvar g = 0; g < N_PSLOT; g++) begin : g_slot
    localparam logic [ADDR_W-1:0] BASE = PSLOT_BASE + ADDR_W'(g * SLOT_BYTES);
    assign slot_hit[g] = folded[ADDR_W-1:SLOT_AW] == BASE[ADDR_W-1:SLOT_AW];
  end

  // direct secure-only window first, folded decode after, error last
  always_comb begin
    tgt    = '0;
    offset = folded;
    if (direct_hit) begin
      tgt[IDX_CTL_S] = 1'b1;
      offset         = addr & SLOT_MASK;
    end else if (sram_hit) begin
      tgt[IDX_SRAM] = 1'b1;
      offset        = folded & SRAM_MASK;
    end else if (|slot_hit) begin
      tgt[IDX_PSLOT0 +: N_PSLOT] = slot_hit;
      offset                     = folded & SLOT_MASK;
    end else if (slow_hit) begin
      tgt[IDX_SLOW] = 1'b1;
      offset        = folded & SLOT_MASK;
    end else if (ctl_ns_hit) begin
      tgt[IDX_CTL_NS] = 1'b1;
      offset          = folded & SLOT_MASK;
    end else begin
      tgt[IDX_ERR] = 1'b1;
    end
  end
endmodule

// File: rtl/addr_attr_unit.sv
module addr_attr_unit
  import aau_pkg::*;
#(
  parameter int SRAM_BYTES = 32768,
  parameter int SLOT_BYTES = 4096
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [31:0]       req_addr,
  output logic              rsp_valid,
  output logic [3:0]        rsp_region,
  output logic              rsp_nonsec,
  output logic              rsp_nsc,
  output logic              rsp_exempt,
  output logic [7:0]        rsp_target,
  output logic [31:0]       rsp_offset,
  input  logic              cfg_valid,
  input  logic              cfg_write,
  input  logic              cfg_secure,
  input  logic [1:0]        cfg_wdata,
  output logic [1:0]        cfg_rdata,
  output logic              cfg_denied
);
  attr_t             attr_c;
  logic [N_TGT-1:0]  tgt_c;
  logic [ADDR_W-1:0] off_c;
  logic              direct_hit, folded_any, wr_ok, wr_reject;

  aau_cfg u_cfg (
    .clk(clk), .rst_n(rst_n), .valid(cfg_valid), .write(cfg_write),
    .secure(cfg_secure), .wdata(cfg_wdata), .cfg(cfg_rdata),
    .denied(cfg_denied), .wr_ok(wr_ok), .wr_reject(wr_reject)
  );

  aau_attr u_attr (.addr(req_addr), .cfg(cfg_rdata), .attr(attr_c));

  aau_decode #(.SRAM_BYTES(SRAM_BYTES), .SLOT_BYTES(SLOT_BYTES)) u_dec (
    .addr(req_addr), .tgt(tgt_c), .offset(off_c),
    .direct_hit(direct_hit), .folded_any(folded_any)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      rsp_region <= '0;
      rsp_nonsec <= 1'b0;
      rsp_nsc    <= 1'b0;
      rsp_exempt <= 1'b0;
      rsp_target <= '0;
      rsp_offset <= '0;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        rsp_region <= attr_c.region;
        rsp_nonsec <= attr_c.nonsec;
        rsp_nsc    <= attr_c.nsc;
        rsp_exempt <= attr_c.exempt;
        rsp_target <= tgt_c;
        rsp_offset <= off_c;
      end
    end
  end
endmodule

// File: rtl/aau_checker.sv
module aau_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        rsp_valid,
  input logic [3:0]  rsp_region,
  input logic        rsp_nonsec,
  input logic        rsp_nsc,
  input logic [7:0]  rsp_target,
  input logic [31:0] rsp_offset,
  input logic        cfg_valid,
  input logic        cfg_write,
  input logic        cfg_secure,
  input logic [1:0]  cfg_wdata,
  input logic [1:0]  cfg_rdata,
  input logic        cfg_denied,
  input logic        direct_hit,
  input logic        wr_reject
);
  p_valid_follows_r5: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  p_valid_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);
  p_hold_fields_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> $stable(rsp_target) && $stable(rsp_offset) && $stable(rsp_region));
  p_nonsec_bit_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> rsp_nonsec == ~rsp_region[0]);
  p_nsc_regions_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_nsc) |-> (rsp_region == 4'd1 || rsp_region == 4'd3));
  p_onehot_target_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $countones(rsp_target) == 1);
  p_direct_window_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && direct_hit) |=> rsp_target == 8'h20 && rsp_region == 4'd5);
  p_sec_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_valid && cfg_write && cfg_secure) |=> cfg_rdata == $past(cfg_wdata));
  p_ns_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_reject |=> cfg_denied && $stable(cfg_rdata));
endmodule

bind addr_attr_unit aau_checker u_aau_checker (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .rsp_valid(rsp_valid),
  .rsp_region(rsp_region), .rsp_nonsec(rsp_nonsec), .rsp_nsc(rsp_nsc),
  .rsp_target(rsp_target), .rsp_offset(rsp_offset), .cfg_valid(cfg_valid),
  .cfg_write(cfg_write), .cfg_secure(cfg_secure), .cfg_wdata(cfg_wdata),
  .cfg_rdata(cfg_rdata), .cfg_denied(cfg_denied), .direct_hit(direct_hit),
  .wr_reject(wr_reject)
);

// File: tb/test_addr_attr_unit.sv
`timescale 1ns/1ps
module test_addr_attr_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [31:0] req_addr = '0;
  logic        rsp_valid, rsp_nonsec, rsp_nsc, rsp_exempt;
  logic [3:0]  rsp_region;
  logic [7:0]  rsp_target;
  logic [31:0] rsp_offset;
  logic        cfg_valid = 1'b0, cfg_write = 1'b0, cfg_secure = 1'b0;
  logic [1:0]  cfg_wdata = '0;
  logic [1:0]  cfg_rdata;
  logic        cfg_denied;

  int n_chk = 0, n_bad = 0;
  logic [1:0] m_cfg = 2'b00;

  always #2 clk = ~clk;

  addr_attr_unit i_addr_attr_unit (.*);

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] e_fold(input logic [31:0] a);
    if (a >= 32'h1000_0000 && a < 32'h6000_0000 && a[28]) return a - 32'h1000_0000;
    return a;
  endfunction

  function automatic logic [7:0] e_tgt(input logic [31:0] a);
    logic [31:0] f = e_fold(a);
    if (a >= 32'h5008_0000 && a < 32'h5008_1000) return 8'h20;
    if (f >= 32'h2000_0000 && f < 32'h2000_8000) return 8'h01;
    if (f >= 32'h4000_0000 && f < 32'h4000_1000) return 8'h02;
    if (f >= 32'h4000_1000 && f < 32'h4000_2000) return 8'h04;
    if (f >= 32'h4000_2000 && f < 32'h4000_3000) return 8'h08;
    if (f >= 32'h4002_F000 && f < 32'h4003_0000) return 8'h10;
    if (f >= 32'h4008_0000 && f < 32'h4008_1000) return 8'h40;
    return 8'h80;
  endfunction

  function automatic logic [31:0] e_off(input logic [31:0] a);
    logic [7:0] t = e_tgt(a);
    if (t == 8'h80) return e_fold(a);
    if (t == 8'h01) return a % 32'h8000;
    return a % 32'h1000;
  endfunction

  function automatic logic e_nsc(input logic [31:0] a, input logic [1:0] c);
    case (a >> 28)
      1: return c[0];
      3: return c[1];
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic e_exempt(input logic [31:0] a);
    return (a >= 32'hE000_0000 && a < 32'hE010_0000) ||
           (a >= 32'hF000_0000 && a < 32'hF010_0000);
  endfunction

  task automatic check_rsp(input logic [31:0] a, input logic [1:0] c);
    chk("R5 rsp_valid", rsp_valid, 1);
    chk("R1 region", rsp_region, a >> 28);
    chk("R1 nonsec", rsp_nonsec, ((a >> 28) % 2) == 0);
    chk("R2 nsc", rsp_nsc, e_nsc(a, c));
    chk("R3 exempt", rsp_exempt, e_exempt(a));
    chk("R7 target", rsp_target, e_tgt(a));
    chk("R6 offset", rsp_offset, e_off(a));
  endtask

  task automatic lookup(input logic [31:0] a);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    check_rsp(a, m_cfg);
  endtask

  task automatic cfg_wr(input logic sec, input logic [1:0] d);
    @(negedge clk);
    cfg_valid = 1'b1; cfg_write = 1'b1; cfg_secure = sec; cfg_wdata = d;
    @(negedge clk);
    cfg_valid = 1'b0; cfg_write = 1'b0;
    if (sec) m_cfg = d;
    chk("R10 cfg_rdata", cfg_rdata, m_cfg);
    chk("R10 cfg_denied", cfg_denied, !sec);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    logic [31:0] a;
    void'($urandom(32'h5EC1));
    repeat (3) @(negedge clk);
    // R4 reset state
    chk("R4 rsp_valid", rsp_valid, 0);
    chk("R4 target", rsp_target, 0);
    chk("R4 offset", rsp_offset, 0);
    chk("R4 cfg_rdata", cfg_rdata, 0);
    chk("R4 cfg_denied", cfg_denied, 0);
    rst_n = 1'b1;

    // R1 R2 R3: every region against every configuration value
    for (int c = 0; c < 4; c++) begin
      cfg_wr(1'b1, 2'(c));
      for (int r = 0; r < 16; r++) lookup({4'(r), 28'h000_0ABC});
    end

    // R6 R7 R8 R9 directed corners
    lookup(32'h2000_0000); lookup(32'h2000_7FFC); lookup(32'h2000_8000);
    lookup(32'h3000_7FFC); lookup(32'h4000_2FFF); lookup(32'h5000_1004);
    lookup(32'h4002_F010); lookup(32'h5002_F010); lookup(32'h4002_E000);
    lookup(32'h4008_0040); lookup(32'h5008_0040); lookup(32'h5008_1000);
    lookup(32'h1000_0004); lookup(32'hE00F_FFFF); lookup(32'hF010_0000);

    // R5 hold: idle cycle keeps fields, valid low
    @(negedge clk);
    chk("R5 idle valid", rsp_valid, 0);
    chk("R5 hold target", rsp_target, e_tgt(32'hF010_0000));

    // R10 rejected non-secure write, then observe through lookup
    cfg_wr(1'b1, 2'b10);
    cfg_wr(1'b0, 2'b01);
    lookup(32'h3000_0000);
    lookup(32'h1000_0000);
    @(negedge clk);
    chk("R10 denied pulse ends", cfg_denied, 0);

    // R11 lookup in same cycle as secure write sees old value
    @(negedge clk);
    req_valid = 1'b1; req_addr = 32'h1000_0100;
    cfg_valid = 1'b1; cfg_write = 1'b1; cfg_secure = 1'b1; cfg_wdata = 2'b11;
    @(negedge clk);
    req_valid = 1'b0; cfg_valid = 1'b0; cfg_write = 1'b0;
    chk("R11 nsc uses old cfg", rsp_nsc, 0);
    chk("R11 cfg updated", cfg_rdata, 2'b11);
    m_cfg = 2'b11;
    lookup(32'h1000_0100);

    // random mix
    for (int i = 0; i < 400; i++) begin
      case ($urandom % 4)
        0: a = $urandom;
        1: a = {4'($urandom % 6), 28'h000_0000} | ($urandom % 32'h9000);
        2: a = {4'(4 + $urandom % 2), 28'h008_0000} | ($urandom % 32'h2000);
        default: a = {4'(4 + $urandom % 2), 28'h002_0000} | ($urandom % 32'h10000);
      endcase
      if ($urandom % 8 == 0) cfg_wr($urandom % 2 == 0, 2'($urandom));
      lookup(a);
    end

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule